// File: doc/BRIEF.md
# Switching Cycle Clock Source Selector

This block chooses the cycle-start clock of a step-down converter. By default it runs an internal period counter that emits one cycle pulse every `INT_PERIOD` reference ticks, which stands in for the free-running oscillator of roughly 185 kHz. It also watches an asynchronous sync input. The input passes through a flop synchronizer, and the block times the interval between rising edges against the fast reference clock.

An edge whose period falls inside the allowed window counts as qualifying. With the default 50 MHz reference, the window of 125 to 227 ticks corresponds to 400 kHz down to 220 kHz. After a run of consecutive qualifying periods, the external edges take over and each one starts a cycle. The block returns to the internal source on the first out-of-window period, or when no edge arrives within a timeout. Every change of source keeps the pulse spacing within the legal range, so it produces neither runt nor doubled cycles.

All of this runs only while `enable` is high. When `enable` is low, the block emits no pulses and forgets any qualification.

Top module: `syncSelect`

## Requirements
- R1: With no valid sync signal, `cyclePulse` goes high for one reference cycle every INT_PERIOD ticks (default 270) and `extActive` stays 0.
- R2: `syncIn` passes through a two-flop synchronizer. `extActive` rises only after QUAL_EDGES (default 3) consecutive in-window periods. From an idle state this means on the 4th rising edge, because the first edge has no measured period.
- R3: While `extActive` is 1, each rising edge of `syncIn` produces one `cyclePulse` exactly 3 reference cycles after the input rises, so the pulse spacing equals the sync period.
- R4: A period of P ticks between rising edges is in-window when 125 <= P <= 227 (MIN_PERIOD, MAX_PERIOD). Sync at 124 or at 228 ticks never activates the external source.
- R5: Any out-of-window period seen during qualification resets the count of consecutive in-window periods to zero.
- R6: While `extActive` is 1, a single out-of-window period clears `extActive` and hands control back to the internal source.
- R7: If no sync edge arrives for TIMEOUT_TICKS (default 260) ticks, `extActive` clears. The next pulse then comes INT_PERIOD ticks after the last external pulse.
- R8: While `enable` is 0 there are no pulses and `extActive` is 0. After `enable` returns high, qualification restarts from zero.
- R9: While enabled, any two consecutive pulses are between MIN_GAP (default 125) and INT_PERIOD ticks apart, including across every change of source.
- R10: During reset `cyclePulse` and `extActive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock used for all timing |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the clock path when high |
| syncIn | input | 1 | Asynchronous external sync signal |
| cyclePulse | output | 1 | One-cycle switching cycle start strobe |
| extActive | output | 1 | 1 when the external sync input is the cycle source |

## Verification
A sync rising edge driven at a falling clock edge reaches the second synchronizer flop after two rising edges. It is seen as an edge in the following cycle and appears on the registered `cyclePulse` at the third falling edge after the drive. The bench samples that exact falling edge and the one before it. `extActive` updates on the same registered step as the qualifying edge's pulse. For that reason the bench reads it only after the train of pulses has finished, a full sync period later and still short of the timeout. Pulse intervals are measured by a monitor that counts falling edges between pulses. Each interval check therefore compares against tick counts derived from the requirements rather than against absolute times.

// File: rtl/syncSelPkg.sv
package syncSelPkg;

  // Measurement strobes from the datapath to the control.
  typedef struct packed {
    logic edgeSeen;   // synchronized rising edge this cycle
    logic inWindow;   // period ending at this edge lies in the window
    logic timeout;    // no edge for the full timeout span
  } syncStatus_t;

  // Control strobes back to the datapath.
  typedef struct packed {
    logic edgeIsCycle; // this edge should start a switching cycle
  } syncCmd_t;

endpackage

// File: rtl/syncDatapath.sv
module syncDatapath
  import syncSelPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int INT_PERIOD    = 270,
  parameter int MIN_PERIOD    = 125,
  parameter int MAX_PERIOD    = 227,
  parameter int TIMEOUT_TICKS = 260,
  parameter int MIN_GAP       = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        syncIn,
  input  syncCmd_t    cmd,
  output syncStatus_t st,
  output logic        cyclePulse
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam int PH_W  = $clog2(INT_PERIOD + 1);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TIMEOUT_TICKS);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] LO_LIM  = CNT_W'(MIN_PERIOD - 1);
  localparam logic [CNT_W-1:0] HI_LIM  = CNT_W'(MAX_PERIOD - 1);
  localparam logic [PH_W-1:0]  PH_WRAP = PH_W'(INT_PERIOD - 1);
  localparam logic [PH_W-1:0]  PH_MIN  = PH_W'(MIN_GAP - 1);

  logic [SYNC_STAGES:0] shReg;
  logic                 riseNow;
  logic [CNT_W-1:0]     periodCnt;
  logic [PH_W-1:0]      phaseCnt;
  logic                 pulseNow;
  logic                 edgeOk;
  logic                 wrapNow;

  // Synchronizer chain plus one flop of history for edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[SYNC_STAGES-1:0], syncIn};
  end

  assign riseNow = shReg[SYNC_STAGES-1] & ~shReg[SYNC_STAGES];

  // periodCnt holds (ticks since last edge) - 1; saturation marks "no period".
  always_comb begin
    st.edgeSeen = riseNow;
    st.inWindow = (periodCnt >= LO_LIM) && (periodCnt <= HI_LIM);
    st.timeout  = !riseNow && (periodCnt == TO_LAST);
  end

  assign edgeOk   = cmd.edgeIsCycle && (phaseCnt >= PH_MIN);
  assign wrapNow  = (phaseCnt == PH_WRAP);
  assign pulseNow = enable && (edgeOk || wrapNow);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      periodCnt  <= CNT_SAT;
      phaseCnt   <= '0;
      cyclePulse <= 1'b0;
    end else begin
      if (riseNow)                 periodCnt <= '0;
      else if (periodCnt != CNT_SAT) periodCnt <= periodCnt + 1'b1;
      phaseCnt   <= pulseNow ? '0 : phaseCnt + 1'b1;
      cyclePulse <= pulseNow;
    end
  end

endmodule

// File: rtl/syncControl.sv
module syncControl
  import syncSelPkg::*;
#(
  parameter int QUAL_EDGES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  syncStatus_t st,
  output syncCmd_t    cmd,
  output logic        extMode
);

  localparam int Q_W = $clog2(QUAL_EDGES + 1);
  localparam logic [Q_W-1:0] Q_LAST = Q_W'(QUAL_EDGES - 1);

  logic [Q_W-1:0] qualCnt;
  logic           goodEdge;
  logic           badEdge;
  logic           lastQual;

  assign goodEdge = st.edgeSeen && st.inWindow;
  assign badEdge  = st.edgeSeen && !st.inWindow;
  assign lastQual = (qualCnt == Q_LAST);

  always_comb cmd.edgeIsCycle = goodEdge && (extMode || lastQual);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      qualCnt <= '0;
      extMode <= 1'b0;
    end else if (extMode) begin
      if (badEdge || st.timeout) begin
        extMode <= 1'b0;
        qualCnt <= '0;
      end
    end else if (goodEdge) begin
      if (lastQual) begin
        extMode <= 1'b1;
        qualCnt <= '0;
      end else begin
        qualCnt <= qualCnt + 1'b1;
      end
    end else if (badEdge || st.timeout) begin
      qualCnt <= '0;
    end
  end

endmodule

// File: rtl/syncSelect.sv
module syncSelect
  import syncSelPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int INT_PERIOD    = 270,
  parameter int MIN_PERIOD    = 125,
  parameter int MAX_PERIOD    = 227,
  parameter int TIMEOUT_TICKS = 260,
  parameter int MIN_GAP       = MIN_PERIOD,
  parameter int QUAL_EDGES    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic syncIn,
  output logic cyclePulse,
  output logic extActive
);

  syncStatus_t status;
  syncCmd_t    command;

  syncDatapath #(
    .SYNC_STAGES(SYNC_STAGES), .INT_PERIOD(INT_PERIOD),
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD),
    .TIMEOUT_TICKS(TIMEOUT_TICKS), .MIN_GAP(MIN_GAP)
  ) uData (
    .clk(clk), .rstN(rstN), .enable(enable), .syncIn(syncIn),
    .cmd(command), .st(status), .cyclePulse(cyclePulse)
  );

  syncControl #(.QUAL_EDGES(QUAL_EDGES)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .st(status), .cmd(command), .extMode(extActive)
  );

endmodule

// File: rtl/syncSelectChecker.sv
module syncSelectChecker
  import syncSelPkg::*;
#(
  parameter int INT_PERIOD = 270,
  parameter int MIN_GAP    = 125
) (
  input logic        clk,
  input logic        rstN,
  input logic        enable,
  input logic        cyclePulse,
  input logic        extActive,
  input syncStatus_t st
);

  localparam int G_W = $clog2(INT_PERIOD + 2) + 1;
  localparam logic [G_W-1:0] G_SAT = {G_W{1'b1}};

  logic [G_W-1:0] gapCnt;
  logic           gapSeen;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      gapCnt  <= G_W'(1);
      gapSeen <= 1'b0;
    end else if (cyclePulse) begin
      gapCnt  <= G_W'(1);
      gapSeen <= 1'b1;
    end else if (gapCnt != G_SAT) begin
      gapCnt  <= gapCnt + 1'b1;
    end
  end

  // R9: pulse spacing stays within [MIN_GAP, INT_PERIOD]
  p_gap_bounds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cyclePulse && gapSeen) |->
      (gapCnt >= G_W'(MIN_GAP) && gapCnt <= G_W'(INT_PERIOD)));

  // R2: handover happens only right after an in-window edge
  p_rise_on_good_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extActive) |-> $past(st.edgeSeen && st.inWindow));

  // R6, R7: fallback only after a bad period, a timeout, or disable
  p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(extActive) && $past(enable)) |->
      $past((st.edgeSeen && !st.inWindow) || st.timeout));

  // R8: disabled path emits nothing
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!cyclePulse && !extActive));

  // R10: reset state
  p_reset_state_r10: assert property (@(posedge clk)
    !rstN |=> (!cyclePulse && !extActive));

endmodule

bind syncSelect syncSelectChecker #(
  .INT_PERIOD(INT_PERIOD), .MIN_GAP(MIN_GAP)
) chk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .cyclePulse(cyclePulse), .extActive(extActive), .st(status)
);

// File: tb/syncSelect_test.sv
`timescale 1ns/1ps
module syncSelect_test;

  localparam int INT_PERIOD = 270;
  localparam int MIN_GAP    = 125;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic syncIn = 1'b0;
  logic cyclePulse;
  logic extActive;

  int checks = 0;
  int errors = 0;
  int since = 0;
  int lastInterval = 0;
  int badGaps = 0;
  int pulseTotal = 0;
  bit prevSeen = 1'b0;

  always #10 clk = ~clk;

  syncSelect uut (
    .clk(clk), .rstN(rstN), .enable(enable), .syncIn(syncIn),
    .cyclePulse(cyclePulse), .extActive(extActive)
  );

  // Interval monitor, sampled on falling edges
  always @(negedge clk) begin
    if (cyclePulse) pulseTotal++;
    if (!rstN || !enable) begin
      prevSeen = 1'b0;
      since = 0;
    end else if (cyclePulse) begin
      if (prevSeen) begin
        lastInterval = since;
        if (since < MIN_GAP || since > INT_PERIOD) badGaps++;
      end
      prevSeen = 1'b1;
      since = 1;
    end else begin
      since++;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic freshStart();
    enable = 1'b0;
    syncIn = 1'b0;
    waitCycles(5);
    enable = 1'b1;
    waitCycles(1);
  endtask

  // count rising edges spaced per ticks apart; each waits a full period
  task automatic syncPulses(input int per, input int count);
    for (int i = 0; i < count; i++) begin
      syncIn = 1'b1;
      waitCycles(4);
      syncIn = 1'b0;
      waitCycles(per - 4);
    end
  endtask

  task automatic testReset();
    waitCycles(5);
    checkEq("R10 cyclePulse in reset", int'(cyclePulse), 0);
    checkEq("R10 extActive in reset", int'(extActive), 0);
    rstN = 1'b1;
  endtask

  task automatic testFreeRun();
    freshStart();
    waitCycles(700);
    checkEq("R1 internal interval", lastInterval, INT_PERIOD);
    checkEq("R1 extActive idle", int'(extActive), 0);
  endtask

  task automatic testHandover();
    freshStart();
    syncPulses(200, 3);
    checkEq("R2 not active after 3 edges", int'(extActive), 0);
    syncPulses(200, 1);
    checkEq("R2 active after 4th edge", int'(extActive), 1);
  endtask

  task automatic testFollow();
    freshStart();
    syncPulses(200, 5);
    syncPulses(180, 4);
    checkEq("R3 interval follows sync", lastInterval, 180);
    syncIn = 1'b1;
    waitCycles(2);
    checkEq("R3 no pulse 2 cycles after edge", int'(cyclePulse), 0);
    waitCycles(1);
    checkEq("R3 pulse 3 cycles after edge", int'(cyclePulse), 1);
    waitCycles(1);
    syncIn = 1'b0;
    waitCycles(176);
    checkEq("R3 still external", int'(extActive), 1);
  endtask

  task automatic testWindow();
    freshStart();
    syncPulses(124, 8);
    checkEq("R4 period 124 rejected", int'(extActive), 0);
    freshStart();
    syncPulses(228, 8);
    checkEq("R4 period 228 rejected", int'(extActive), 0);
    freshStart();
    syncPulses(125, 4);
    checkEq("R4 period 125 accepted", int'(extActive), 1);
    freshStart();
    syncPulses(227, 4);
    checkEq("R4 period 227 accepted", int'(extActive), 1);
  endtask

  task automatic testCountReset();
    freshStart();
    syncPulses(200, 2);
    syncPulses(100, 1);  // next period is short
    syncPulses(200, 2);
    checkEq("R5 count cleared by bad period", int'(extActive), 0);
    syncPulses(200, 1);
    checkEq("R5 still counting", int'(extActive), 0);
    syncPulses(200, 1);
    checkEq("R5 qualifies after fresh run", int'(extActive), 1);
  endtask

  task automatic testBadInExt();
    freshStart();
    syncPulses(200, 5);
    checkEq("R6 active before bad period", int'(extActive), 1);
    syncPulses(100, 1);
    syncPulses(200, 1);
    checkEq("R6 fallback on bad period", int'(extActive), 0);
  endtask

  task automatic testTimeout();
    freshStart();
    syncPulses(200, 6);
    waitCycles(40);
    checkEq("R7 active before timeout", int'(extActive), 1);
    waitCycles(60);
    checkEq("R7 fallback after timeout", int'(extActive), 0);
    waitCycles(300);
    checkEq("R7 internal interval after stop", lastInterval, INT_PERIOD);
  endtask

  task automatic testEnable();
    int snap;
    freshStart();
    syncPulses(200, 5);
    checkEq("R8 active before disable", int'(extActive), 1);
    enable = 1'b0;
    waitCycles(2);
    checkEq("R8 extActive cleared", int'(extActive), 0);
    snap = pulseTotal;
    syncPulses(200, 5);
    checkEq("R8 no pulses while disabled", pulseTotal - snap, 0);
    checkEq("R8 inactive while disabled", int'(extActive), 0);
    enable = 1'b1;
    syncPulses(200, 2);
    checkEq("R8 requalify after enable", int'(extActive), 0);
  endtask

  initial begin
    testReset();
    testFreeRun();
    testHandover();
    testFollow();
    testWindow();
    testCountReset();
    testBadInExt();
    testTimeout();
    testEnable();
    checkEq("R9 out-of-range pulse gaps", badGaps, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule